// File: doc/BRIEF.md
# Programmable Pulse Burst Generator

This block drives a single digital output with a burst of rectangular pulses. The burst length is set by a target pulse count. Each pulse's shape is set by two durations counted in system clock cycles: the time the output stays low before each pulse, and the time it stays high. The output rate is therefore the clock rate divided by the sum of the two counts, rounded to whole cycles. A start command begins a burst and an abort command ends it at once. While a burst runs, the block reports that it is busy and how many pulses it has completed. When the burst ends, for any reason, it gives a one-cycle completion strobe.

The target count and both durations are live inputs and are never copied into a shadow register. A new duration takes effect when the next low or high phase begins, so a phase already under way keeps the length it started with. A new target takes effect on the next clock. If the new target is at or below the pulses already completed, the burst stops, even in the middle of a pulse. If it is higher, the burst continues until the completed count reaches it. Each cycle, one down-counter and two comparisons decide the output level. The design has no nested timing structure.

Top module: `pulse_burst_gen`

## Requirements
- R1: While reset is held and after it is released, `pulse_o`, `busy_o` and `done_o` are 0 and `sent_o` is 0.
- R2: A `start_i` sampled high while idle sets `busy_o` from the next clock. There is one setup cycle, then `low_i` low cycles, then `high_i` high cycles. After that, each further pulse is preceded by `low_i` low cycles. While `busy_o` is high, the first high run of `pulse_o` therefore follows 1+`low_i` low cycles.
- R3: With an unchanged target N greater than 0, exactly N pulses are emitted. On the clock edge that ends the last high phase, `busy_o` and `pulse_o` fall together and `sent_o` reads N. `sent_o` increases by exactly one per completed pulse and holds its value while idle.
- R4: `done_o` is high for exactly one cycle, on the cycle in which `busy_o` has just fallen. This holds for a normal finish, a stop caused by a lowered target, and an abort.
- R5: A value of 0 on `high_i` or `low_i` acts as 1, so the shortest pulse period is two cycles.
- R6: A change to `high_i` or `low_i` during a burst leaves the phase in progress at its original length. It applies from the next phase of that kind, and the burst is not restarted.
- R7: If `target_i` is changed during a burst to a value at or below `sent_o`, the block goes idle on the next clock edge with `pulse_o` low, and it emits no further pulse.
- R8: If `target_i` is raised during a burst above `sent_o`, the burst continues until `sent_o` equals the new target.
- R9: `abort_i` sampled high while busy returns the block to idle on that edge, with `pulse_o` low and `sent_o` kept at its value. `pulse_o` is never high while `busy_o` is low.
- R10: `start_i` while busy is ignored. The pulse sequence and final count are unchanged.
- R11: A burst started with target 0 produces no pulse. `busy_o` stays high for two cycles (setup and one low cycle), then `done_o` strobes with `sent_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a burst (sampled while idle) |
| abort_i | input | 1 | End the running burst at once |
| target_i | input | CNT_W | Requested number of pulses, live |
| high_i | input | TIME_W | High-phase length in clock cycles (0 acts as 1) |
| low_i | input | TIME_W | Low-phase length in clock cycles (0 acts as 1) |
| pulse_o | output | 1 | Pulse train output, registered |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle strobe when a burst ends |
| sent_o | output | CNT_W | Pulses completed in the current or last burst |

## Verification
`busy_o` rises one edge after `start_i` is sampled. `pulse_o` rises 1+low cycles later and falls after high cycles. `sent_o` steps on the same edge as the fall. `done_o` and the drop of `busy_o` appear on the edge after the stopping cause is sampled: an abort, a lowered target, or the end of the last high phase. A monitor samples the outputs at the falling clock edge. It measures each low and high run of `pulse_o` while busy and pops the expected run lengths that the driver queued from the requirements. Mid-burst changes to the target and durations are applied at a falling edge. The queued lengths account for the phase that was already loaded when the change arrived.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_GAP   = 2'd2,
    ST_HIGH  = 2'd3
  } pbg_state_e;
endpackage

// File: rtl/pbg_phase_timer.sv
module pbg_phase_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [TIME_W-1:0] len_i,
  input  logic              run_i,
  output logic              expired_o
);
  logic [TIME_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  // A zero length behaves like one cycle: the reload value saturates at 0.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = (len_i == '0) ? '0 : len_i - 1'b1;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_en)  cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_zero_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (len_i == '0)) |=> expired_o);
endmodule

// File: rtl/pbg_tally.sv
module pbg_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] target_i,
  output logic [CNT_W-1:0] sent_o,
  output logic             last_o,
  output logic             stop_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] sent_q, sent_d;
  logic             sent_en;
  logic [EXT_W-1:0] next_ext;

  always_comb begin
    sent_d  = sent_q;
    sent_en = 1'b0;
    if (clr_i) begin
      sent_en = 1'b1;
      sent_d  = '0;
    end else if (inc_i) begin
      sent_en = 1'b1;
      sent_d  = sent_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sent_q <= '0;
    else if (sent_en)  sent_q <= sent_d;
  end

  assign next_ext = {1'b0, sent_q} + EXT_W'(1);
  // the pulse now finishing reaches the live target
  assign last_o   = (next_ext >= {1'b0, target_i});
  // live target already met or undercut
  assign stop_o   = (target_i <= sent_q);
  assign sent_o   = sent_q;

  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i) |=> (sent_q == $past(sent_q) + 1'b1));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !clr_i) |=> $stable(sent_q));
endmodule

// File: rtl/pbg_ctrl.sv
module pbg_ctrl
  import pbg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  input  logic expired_i,
  input  logic last_i,
  input  logic stop_i,
  output logic load_o,
  output logic sel_high_o,
  output logic run_o,
  output logic clr_o,
  output logic inc_o,
  output logic busy_o,
  output logic pulse_o,
  output logic done_o
);
  pbg_state_e state_q, state_d;
  logic       pulse_q, done_q, done_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    sel_high_o = 1'b0;
    run_o      = 1'b0;
    clr_o      = 1'b0;
    inc_o      = 1'b0;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && !abort_i) state_d = ST_SETUP;
      end
      ST_SETUP: begin
        if (abort_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_GAP;
          clr_o   = 1'b1;
          load_o  = 1'b1;
        end
      end
      ST_GAP: begin
        if (abort_i || stop_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (expired_i) begin
          state_d    = ST_HIGH;
          load_o     = 1'b1;
          sel_high_o = 1'b1;
        end else begin
          run_o = 1'b1;
        end
      end
      ST_HIGH: begin
        if (abort_i || stop_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (expired_i) begin
          inc_o = 1'b1;
          if (last_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_GAP;
            load_o  = 1'b1;
          end
        end else begin
          run_o = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pulse_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= (state_d == ST_HIGH);
      done_q  <= done_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign pulse_o = pulse_q;
  assign done_o  = done_q;

  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (state_q == ST_IDLE));

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_SETUP));

  p_stop_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_GAP || state_q == ST_HIGH) && stop_i) |=> (!pulse_q && state_q == ST_IDLE));
endmodule

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen #(
  parameter int CNT_W  = 16,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [CNT_W-1:0]  target_i,
  input  logic [TIME_W-1:0] high_i,
  input  logic [TIME_W-1:0] low_i,
  output logic              pulse_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  sent_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[SYNC_STAGES-1];

  logic              load, sel_high, run, clr, inc;
  logic              expired, last, stop;
  logic [TIME_W-1:0] phase_len;

  assign phase_len = sel_high ? high_i : low_i;

  pbg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start_i   (start_i),
    .abort_i   (abort_i),
    .expired_i (expired),
    .last_i    (last),
    .stop_i    (stop),
    .load_o    (load),
    .sel_high_o(sel_high),
    .run_o     (run),
    .clr_o     (clr),
    .inc_o     (inc),
    .busy_o    (busy_o),
    .pulse_o   (pulse_o),
    .done_o    (done_o)
  );

  pbg_phase_timer #(.TIME_W(TIME_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load_i   (load),
    .len_i    (phase_len),
    .run_i    (run),
    .expired_o(expired)
  );

  pbg_tally #(.CNT_W(CNT_W)) u_tally (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .clr_i   (clr),
    .inc_i   (inc),
    .target_i(target_i),
    .sent_o  (sent_o),
    .last_o  (last),
    .stop_o  (stop)
  );

  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !busy_o |-> !pulse_o);

  p_done_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    done_o |=> !done_o);

  p_done_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(busy_o) |-> done_o);

  p_idle_count_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy_o && !start_i) |=> $stable(sent_o));
endmodule

// File: tb/pulse_burst_gen_tb.sv
module pulse_burst_gen_tb;
  localparam int CW = 16;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, abort_i;
  logic [CW-1:0] target_i;
  logic [TW-1:0] high_i, low_i;
  logic          pulse_o, busy_o, done_o;
  logic [CW-1:0] sent_o;

  int checks = 0;
  int errors = 0;
  int wd     = 0;

  always #4 clk = ~clk;

  pulse_burst_gen #(.CNT_W(CW), .TIME_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
    .target_i(target_i), .high_i(high_i), .low_i(low_i),
    .pulse_o(pulse_o), .busy_o(busy_o), .done_o(done_o), .sent_o(sent_o)
  );

  typedef struct {
    bit    lvl;
    int    len;
    string req;
  } run_item_t;

  run_item_t exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic expect_run(input bit lvl, input int len, input string req);
    run_item_t it;
    it.lvl = lvl; it.len = len; it.req = req;
    exp_q.push_back(it);
  endtask

  // scoreboard monitor: measures each level run while busy
  bit mon_en = 0;
  bit prev_busy = 0;
  bit prev_lvl = 0;
  int run_len = 0;

  task automatic report_run(input bit lvl, input int len);
    run_item_t it;
    if (exp_q.size() == 0) begin
      check(0, "unexpected run", len, 0);
    end else begin
      it = exp_q.pop_front();
      check(it.lvl == lvl, it.req, int'(lvl), int'(it.lvl));
      check(it.len == len, it.req, len, it.len);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (busy_o) begin
        if (!prev_busy) begin
          run_len  = 0;
          prev_lvl = 1'b0;
        end
        if (pulse_o == prev_lvl) run_len++;
        else begin
          report_run(prev_lvl, run_len);
          prev_lvl = pulse_o;
          run_len  = 1;
        end
      end else if (prev_busy && prev_lvl) begin
        report_run(1'b1, run_len);
      end
      prev_busy = busy_o;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      check(0, "watchdog", wd, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic start_burst();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_end(input string req, input int exp_sent);
    int n = 0;
    while (busy_o && n < 2000) begin
      @(negedge clk);
      abort_i = 1'b0;
      n++;
    end
    check(!busy_o, {req, " busy end"}, int'(busy_o), 0);
    check(done_o, {"R4 done strobe ", req}, int'(done_o), 1);
    check(!pulse_o, {req, " output low"}, int'(pulse_o), 0);
    check(sent_o == exp_sent, {req, " sent count"}, int'(sent_o), exp_sent);
    @(negedge clk);
    check(!done_o, {"R4 done single cycle ", req}, int'(done_o), 0);
    check(exp_q.size() == 0, {req, " runs left"}, exp_q.size(), 0);
  endtask

  task automatic wait_sent(input int v);
    while (sent_o != CW'(v)) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; abort_i = 1'b0;
    target_i = '0; high_i = '0; low_i = '0;
    repeat (3) @(negedge clk);
    check(!pulse_o && !busy_o && !done_o && sent_o == 0, "R1 in reset", int'(busy_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!pulse_o && !busy_o && !done_o && sent_o == 0, "R1 after reset", int'(sent_o), 0);
    mon_en = 1'b1;

    // R2, R3, R10: three pulses, high 2, low 3, stray start mid-burst
    target_i = 3; high_i = 2; low_i = 3;
    expect_run(0, 4, "R2 first gap");
    expect_run(1, 2, "R2 high");
    expect_run(0, 3, "R2 gap");
    expect_run(1, 2, "R2 high");
    expect_run(0, 3, "R2 gap");
    expect_run(1, 2, "R3 last high");
    start_burst();
    check(busy_o, "R2 busy after start", int'(busy_o), 1);
    repeat (5) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    wait_end("R3 R10", 3);
    repeat (3) @(negedge clk);
    check(sent_o == 3, "R3 count holds idle", int'(sent_o), 3);

    // R5: zero lengths act as one
    target_i = 2; high_i = 0; low_i = 0;
    expect_run(0, 2, "R5 gap");
    expect_run(1, 1, "R5 high");
    expect_run(0, 1, "R5 gap");
    expect_run(1, 1, "R5 high");
    start_burst();
    wait_end("R5", 2);

    // R7: target lowered below completed count
    target_i = 10; high_i = 2; low_i = 2;
    expect_run(0, 3, "R7 gap");
    expect_run(1, 2, "R7 high");
    expect_run(0, 2, "R7 gap");
    expect_run(1, 2, "R7 high");
    expect_run(0, 2, "R7 gap");
    expect_run(1, 2, "R7 high");
    start_burst();
    wait_sent(3);
    target_i = 2;
    @(negedge clk);
    wait_end("R7", 3);

    // R8: target raised mid-burst
    target_i = 2; high_i = 1; low_i = 2;
    expect_run(0, 3, "R8 gap");
    for (int i = 0; i < 4; i++) begin
      if (i > 0) expect_run(0, 2, "R8 gap");
      expect_run(1, 1, "R8 high");
    end
    start_burst();
    wait_sent(1);
    target_i = 4;
    wait_end("R8", 4);

    // R6: durations changed during the first inter-pulse gap
    target_i = 4; high_i = 2; low_i = 2;
    expect_run(0, 3, "R6 gap");
    expect_run(1, 2, "R6 old high");
    expect_run(0, 2, "R6 gap in progress");
    expect_run(1, 4, "R6 new high");
    expect_run(0, 5, "R6 new gap");
    expect_run(1, 4, "R6 new high");
    expect_run(0, 5, "R6 new gap");
    expect_run(1, 4, "R6 new high");
    start_burst();
    wait_sent(1);
    high_i = 4; low_i = 5;
    wait_end("R6", 4);

    // R9: abort in the middle of the second pulse
    target_i = 5; high_i = 6; low_i = 2;
    expect_run(0, 3, "R9 gap");
    expect_run(1, 6, "R9 high");
    expect_run(0, 2, "R9 gap");
    expect_run(1, 3, "R9 cut high");
    start_burst();
    while (!(pulse_o && sent_o == 1)) @(negedge clk);
    repeat (2) @(negedge clk);
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
    check(!busy_o && !pulse_o, "R9 idle after abort", int'(pulse_o), 0);
    check(done_o, "R4 done on abort R9", int'(done_o), 1);
    check(sent_o == 1, "R9 count kept", int'(sent_o), 1);
    @(negedge clk);
    check(!done_o, "R4 done single R9", int'(done_o), 0);
    check(exp_q.size() == 0, "R9 runs left", exp_q.size(), 0);

    // R11: zero target
    target_i = 0; high_i = 3; low_i = 3;
    start_burst();
    check(busy_o, "R11 busy setup", int'(busy_o), 1);
    @(negedge clk);
    check(busy_o && !pulse_o, "R11 busy one low cycle", int'(busy_o), 1);
    @(negedge clk);
    check(!busy_o && done_o && !pulse_o, "R11 done no pulse", int'(done_o), 1);
    check(sent_o == 0, "R11 sent zero", int'(sent_o), 0);
    check(exp_q.size() == 0, "R11 no runs", exp_q.size(), 0);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule